// File: doc/BRIEF.md
# Registered/Transparent Bidirectional Bus Transceiver

This block moves data between two ports, called A and B, one path for each direction. Each path has one storage element that can work in three ways. It can pass its input straight through to the far side. It can keep what it holds. It can take in a new word when its strobe falls. Each path also has an output enable. On the A-to-B path the enable is asserted high. On the B-to-A path it is asserted low. Data is never inverted.

The bidirectional pins are split into a separate input bus, output bus and output-enable bit for each port, so the logic stays synthesizable. Whatever sits outside the block combines these into a real tri-state pad. The strobes and the pass controls are plain inputs. The block samples them with its own clock `clk` and clears its storage and edge history on the active-low reset `rst_n`. A strobe fall is seen at the first rising edge of `clk` at which the strobe reads low after having read high at the previous edge. Both strobes and the input data must be held stable across each `clk` edge.

Top module: `xcvr_universal`

## Requirements
- R1: Each path is `WIDTH` bits wide (18 by default). Output bit i always carries input bit i of the same path, without inversion, on every bit position.
- R2: While `ab_pass` is 1, `b_out` equals `a_in` in the same cycle, with no clock edge needed.
- R3: While `ab_pass` is 0 and `ab_strobe` does not fall, `b_out` keeps its value through any number of clock edges. This holds whether the strobe stays high or stays low, and whatever `a_in` does.
- R4: While `ab_pass` is 0, a fall of `ab_strobe` stores the `a_in` value present at the `clk` edge where the fall is seen. `b_out` shows that value from that edge on.
- R5: A rise of `ab_strobe` while `ab_pass` is 0 leaves `b_out` unchanged.
- R6: When `ab_pass` goes from 1 to 0, `b_out` keeps the `a_in` value sampled at the last `clk` edge with `ab_pass` at 1. It keeps that value until the next strobe fall, even if the strobe is high when pass drops.
- R7: `b_oe` is 1 exactly when `ab_drive` is 1, so the enable is active high. When it is 0, the B side is undriven.
- R8: `a_oe` is 1 exactly when `ba_drive_n` is 0, so the enable is active low. When it is 1, the A side is undriven.
- R9: The B-to-A path follows R2 to R6 with `b_in`, `ba_pass`, `ba_strobe` and `a_out`. Activity on one path never changes the output of the other path.
- R10: After reset, both stored words are zero. With both pass inputs at 0, both outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for strobes and storage |
| rst_n | input | 1 | Active-low reset, clears storage and strobe history |
| a_in | input | WIDTH | Value seen on the A pins |
| a_out | output | WIDTH | Value for the A pins (B-to-A path) |
| a_oe | output | 1 | Drive enable for the A pins |
| b_in | input | WIDTH | Value seen on the B pins |
| b_out | output | WIDTH | Value for the B pins (A-to-B path) |
| b_oe | output | 1 | Drive enable for the B pins |
| ab_pass | input | 1 | A-to-B pass-through control, 1 = pass |
| ab_strobe | input | 1 | A-to-B capture strobe, falling edge stores |
| ab_drive | input | 1 | A-to-B output enable, active high |
| ba_pass | input | 1 | B-to-A pass-through control, 1 = pass |
| ba_strobe | input | 1 | B-to-A capture strobe, falling edge stores |
| ba_drive_n | input | 1 | B-to-A output enable, active low |

## Verification
Each path is driven through the same sequence of steps.

1. Walking ones and mixed patterns go through the pass-through mode. This shows a lost or inverted bit on any position.
2. The pass control drops while the strobe is high and the input then changes. This separates "keep the last passed value" from "follow the input".
3. The strobe is held high, then falls, then is held low, then rises, with a fresh input word at each step. This separates a true falling-edge capture from a level capture, a rising-edge capture, or no capture at all.
4. Both drive inputs are toggled while both enables are checked, which exposes a swapped polarity.
5. The other path's output is compared before and after each sweep, to confirm the two paths do not affect each other.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
   localparam int XCVR_DEFAULT_WIDTH = 18;

   typedef enum logic [1:0] {
      SM_KEEP    = 2'd0,
      SM_FOLLOW  = 2'd1,
      SM_CAPTURE = 2'd2
   } store_mode_e;
endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det #(
   parameter bit FALLING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   output logic hit
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= strobe;
   end

   generate
      if (FALLING) begin : g_fall
         assign hit = prev & ~strobe;
      end else begin : g_rise
         assign hit = ~prev & strobe;
      end
   endgenerate
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
   import xcvr_pkg::*;
#(
   parameter int WIDTH = XCVR_DEFAULT_WIDTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pass,
   input  logic             hit,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] y
);
   store_mode_e      mode;
   logic [WIDTH-1:0] held;

   always_comb begin
      if (pass)     mode = SM_FOLLOW;
      else if (hit) mode = SM_CAPTURE;
      else          mode = SM_KEEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held <= '0;
      end else begin
         case (mode)
            SM_FOLLOW, SM_CAPTURE: held <= d;
            default:               held <= held;
         endcase
      end
   end

   assign y = pass ? d : held;
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
   import xcvr_pkg::*;
#(
   parameter int WIDTH           = XCVR_DEFAULT_WIDTH,
   parameter bit OE_ACTIVE_LOW   = 1'b0,
   parameter bit CAPTURE_ON_FALL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   input  logic             pass,
   input  logic             strobe,
   input  logic             drive,
   output logic [WIDTH-1:0] d_out,
   output logic             oe
);
   logic hit;

   xcvr_edge_det #(
      .FALLING(CAPTURE_ON_FALL)
   ) i_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .strobe(strobe),
      .hit   (hit)
   );

   xcvr_store #(
      .WIDTH(WIDTH)
   ) i_store (
      .clk  (clk),
      .rst_n(rst_n),
      .pass (pass),
      .hit  (hit),
      .d    (d_in),
      .y    (d_out)
   );

   generate
      if (OE_ACTIVE_LOW) begin : g_oe_low
         assign oe = ~drive;
      end else begin : g_oe_high
         assign oe = drive;
      end
   endgenerate
endmodule

// File: rtl/xcvr_universal.sv
module xcvr_universal
   import xcvr_pkg::*;
#(
   parameter int WIDTH = XCVR_DEFAULT_WIDTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic             a_oe,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic             b_oe,
   input  logic             ab_pass,
   input  logic             ab_strobe,
   input  logic             ab_drive,
   input  logic             ba_pass,
   input  logic             ba_strobe,
   input  logic             ba_drive_n
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("xcvr_universal: WIDTH must be at least 1");
      end
   endgenerate

   xcvr_lane #(
      .WIDTH          (WIDTH),
      .OE_ACTIVE_LOW  (1'b0),
      .CAPTURE_ON_FALL(1'b1)
   ) i_lane_ab (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (a_in),
      .pass  (ab_pass),
      .strobe(ab_strobe),
      .drive (ab_drive),
      .d_out (b_out),
      .oe    (b_oe)
   );

   xcvr_lane #(
      .WIDTH          (WIDTH),
      .OE_ACTIVE_LOW  (1'b1),
      .CAPTURE_ON_FALL(1'b1)
   ) i_lane_ba (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (b_in),
      .pass  (ba_pass),
      .strobe(ba_strobe),
      .drive (ba_drive_n),
      .d_out (a_out),
      .oe    (a_oe)
   );
endmodule

// File: rtl/xcvr_universal_chk.sv
module xcvr_universal_chk #(
   parameter int WIDTH = 18
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] a_out,
   input logic             a_oe,
   input logic [WIDTH-1:0] b_in,
   input logic [WIDTH-1:0] b_out,
   input logic             b_oe,
   input logic             ab_pass,
   input logic             ab_strobe,
   input logic             ab_drive,
   input logic             ba_pass,
   input logic             ba_strobe,
   input logic             ba_drive_n
);
   AST_AB_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      ab_pass |-> (b_out == a_in)); // R2

   AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ab_pass && !$past(ab_pass) && !($past(ab_strobe, 2) && !$past(ab_strobe)))
      |-> $stable(b_out)); // R3

   AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !ab_pass && $past(ab_strobe) && !ab_strobe)
      |=> (ab_pass || (b_out == $past(a_in)))); // R4

   AST_BA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      ba_pass |-> (a_out == b_in)); // R9

   AST_BA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ba_pass && !$past(ba_pass) && !($past(ba_strobe, 2) && !$past(ba_strobe)))
      |-> $stable(a_out)); // R9

   AST_BA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !ba_pass && $past(ba_strobe) && !ba_strobe)
      |=> (ba_pass || (a_out == $past(b_in)))); // R9

   AST_B_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      b_oe == ab_drive); // R7

   AST_A_OE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      a_oe == !ba_drive_n); // R8
endmodule

bind xcvr_universal xcvr_universal_chk #(.WIDTH(WIDTH)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .a_in      (a_in),
   .a_out     (a_out),
   .a_oe      (a_oe),
   .b_in      (b_in),
   .b_out     (b_out),
   .b_oe      (b_oe),
   .ab_pass   (ab_pass),
   .ab_strobe (ab_strobe),
   .ab_drive  (ab_drive),
   .ba_pass   (ba_pass),
   .ba_strobe (ba_strobe),
   .ba_drive_n(ba_drive_n)
);

// File: tb/test_xcvr_universal.sv
module test_xcvr_universal;
   localparam int W = 18;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [W-1:0] a_in, a_out, b_in, b_out;
   logic         a_oe, b_oe;
   logic         ab_pass, ab_strobe, ab_drive;
   logic         ba_pass, ba_strobe, ba_drive_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   xcvr_universal #(.WIDTH(W)) i_xcvr_universal (
      .clk       (clk),
      .rst_n     (rst_n),
      .a_in      (a_in),
      .a_out     (a_out),
      .a_oe      (a_oe),
      .b_in      (b_in),
      .b_out     (b_out),
      .b_oe      (b_oe),
      .ab_pass   (ab_pass),
      .ab_strobe (ab_strobe),
      .ab_drive  (ab_drive),
      .ba_pass   (ba_pass),
      .ba_strobe (ba_strobe),
      .ba_drive_n(ba_drive_n)
   );

   task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [W-1:0] pat(input int k);
      logic [W-1:0] v;
      for (int i = 0; i < W; i++) v[i] = (((i * 7) + (k * 3)) % 5) < 2;
      return v;
   endfunction

   task automatic set_data(input bit dir, input logic [W-1:0] v);
      if (dir) b_in = v; else a_in = v;
   endtask

   task automatic set_pass(input bit dir, input logic v);
      if (dir) ba_pass = v; else ab_pass = v;
   endtask

   task automatic set_strobe(input bit dir, input logic v);
      if (dir) ba_strobe = v; else ab_strobe = v;
   endtask

   function automatic logic [W-1:0] out_of(input bit dir);
      return dir ? a_out : b_out;
   endfunction

   function automatic logic [W-1:0] other_of(input bit dir);
      return dir ? b_out : a_out;
   endfunction

   task automatic sweep(input bit dir, input string tag);
      logic [W-1:0] other_before;
      logic [W-1:0] p1, p3, p5;
      other_before = other_of(dir);
      // R1 / R2: walking ones in pass-through
      set_pass(dir, 1'b1);
      for (int i = 0; i < W; i++) begin
         set_data(dir, {{(W-1){1'b0}}, 1'b1} << i);
         #1;
         chk({tag, " R1 walking one"}, out_of(dir), {{(W-1){1'b0}}, 1'b1} << i);
      end
      // R2: mixed patterns and their complements
      for (int k = 0; k < 6; k++) begin
         set_data(dir, pat(k));
         #1;
         chk({tag, " R2 pass"}, out_of(dir), pat(k));
         set_data(dir, ~pat(k));
         #1;
         chk({tag, " R2 pass inverse"}, out_of(dir), ~pat(k));
      end
      // R6: pass drops with strobe high
      p1 = pat(7);
      set_strobe(dir, 1'b1);
      set_data(dir, p1);
      tick();
      set_pass(dir, 1'b0);
      set_data(dir, pat(8));
      #1;
      chk({tag, " R6 last passed kept"}, out_of(dir), p1);
      // R3: strobe held high
      tick();
      tick();
      chk({tag, " R3 hold strobe high"}, out_of(dir), p1);
      // R4: falling edge captures
      p3 = pat(9) ^ {W{1'b1}};
      set_data(dir, p3);
      set_strobe(dir, 1'b0);
      tick();
      chk({tag, " R4 capture on fall"}, out_of(dir), p3);
      // R3: strobe held low
      set_data(dir, pat(10));
      tick();
      tick();
      tick();
      chk({tag, " R3 hold strobe low"}, out_of(dir), p3);
      // R5: rise ignored
      set_data(dir, pat(11));
      set_strobe(dir, 1'b1);
      tick();
      chk({tag, " R5 rise ignored"}, out_of(dir), p3);
      tick();
      chk({tag, " R5 rise ignored later"}, out_of(dir), p3);
      // R4: second capture
      p5 = pat(12);
      set_data(dir, p5);
      set_strobe(dir, 1'b0);
      tick();
      chk({tag, " R4 second capture"}, out_of(dir), p5);
      set_data(dir, '0);
      tick();
      chk({tag, " R3 after second capture"}, out_of(dir), p5);
      // R9: other path untouched
      chk({tag, " R9 other path unchanged"}, other_of(dir), other_before);
   endtask

   initial begin
      rst_n      = 1'b0;
      a_in       = '0;
      b_in       = '0;
      ab_pass    = 1'b0;
      ab_strobe  = 1'b0;
      ab_drive   = 1'b0;
      ba_pass    = 1'b0;
      ba_strobe  = 1'b0;
      ba_drive_n = 1'b1;
      repeat (3) tick();
      rst_n = 1'b1;
      a_in  = pat(1);
      b_in  = pat(2);
      tick();
      chk("R10 reset b_out", b_out, '0);
      chk("R10 reset a_out", a_out, '0);

      // R7 / R8: enable polarity, all four combinations
      for (int m = 0; m < 4; m++) begin
         ab_drive   = m[0];
         ba_drive_n = m[1];
         #1;
         chk("R7 b_oe", {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, m[0]});
         chk("R8 a_oe", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, ~m[1]});
      end
      ab_drive   = 1'b1;
      ba_drive_n = 1'b0;

      sweep(1'b0, "AB");
      sweep(1'b1, "BA R9");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule